// File: doc/BRIEF.md
# Privileged Exception Entry and Return Unit

This block decides where instruction fetch goes when the core enters or leaves privileged handler code. When an exception is signalled, it records a restart address and sends fetch to a handler address built from a base register and a per-cause vector offset. For a trap, including a deliberate call into privileged code, the restart address is the instruction after the current one. For a fault, it is the faulting instruction itself, so that instruction runs again.

The privileged-mode flag is carried in bit 0 of the program counter. Every handler address has bit 0 set. A saved restart address keeps the bit 0 of the PC that was current when the exception was taken. A return request reloads fetch from the saved address, and bit 0 of that address decides whether the core stays privileged. Fetch logic can attach this bit to each fetched instruction as an extra bit 32 of a 33-bit instruction word.

The handler base and the restart address can both be written through a small register write port. Writes take effect only while the core is privileged.

Top module: `exc_redirect`

## Requirements
- R1: After reset: `privMode` is 1, `redirValid` is 0, `excAddr` is 0, `palBase` is `RESET_BASE`, `nextPc` is `RESET_BASE` with bit 0 set, and `nextNextPc` is `nextPc + 4`.
- R2: Suppose `excValid` is 1 and `excIsTrap` is 1 at a clock edge. After that edge, `excAddr` holds `curPc + 4`.
- R3: Suppose `excValid` is 1 and `excIsTrap` is 0 at a clock edge. After that edge, `excAddr` holds `curPc` unchanged.
- R4: For the cycle after an exception edge, `redirValid` is 1 and `nextPc` is `palBase + vecOffset` with bit 0 forced to 1. `palBase` here is the value before the edge, and `vecOffset` is zero-extended.
- R5: Whenever `redirValid` is 1, `nextNextPc` equals `nextPc + 4`.
- R6: An exception edge leaves `privMode` at 1.
- R7: A return edge (`retReq` is 1 and `excValid` is 0) has three effects for the next cycle. `redirValid` is 1. `nextPc` equals the `excAddr` held before the edge. `privMode` equals bit 0 of that address.
- R8: If `excValid` and `retReq` are both 1 at the same edge, the exception is taken and the return is dropped.
- R9: A write with `regWrEn` is 1 is ignored while `privMode` is 0, and both `palBase` and `excAddr` keep their values. While `privMode` is 1, the write goes to the register chosen by `regWrSel`: 0 selects `palBase` and 1 selects `excAddr`.
- R10: If an exception and a privileged write to `excAddr` land on the same edge, `excAddr` takes the exception's restart address.
- R11: On an edge with neither an exception nor a return, `redirValid` goes to 0 and `nextPc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPc | input | PC_W | PC of the instruction at the exception point; bit 0 is the mode flag |
| excValid | input | 1 | Take an exception at this edge |
| excIsTrap | input | 1 | 1: trap (restart after the instruction), 0: fault (restart at it) |
| vecOffset | input | VEC_W | Handler offset for this cause |
| retReq | input | 1 | Return from privileged code |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | 0: handler base, 1: restart address |
| regWrData | input | PC_W | Write data |
| redirValid | output | 1 | Fetch must be redirected to nextPc this cycle |
| nextPc | output | PC_W | Redirected fetch PC |
| nextNextPc | output | PC_W | PC of the following instruction |
| privMode | output | 1 | Current privileged-mode state |
| excAddr | output | PC_W | Saved restart address |
| palBase | output | PC_W | Handler base register |

## Verification
A wrong restart address shows on `excAddr` one cycle after the exception. It also shows on `nextPc` one cycle after the next return. A wrong mode state has two visible effects. Right after a return, `privMode` no longer matches bit 0 of the old restart address. Later, register writes in user mode go through, or writes in privileged mode are dropped, and the next readout of `palBase` or `excAddr` shows this. A priority error between exception and return shows at once, because `nextPc` carries the restart address where the handler address should be.

// File: rtl/exc_redirect_pkg.sv
package exc_redirect_pkg;
  localparam logic SEL_BASE = 1'b0;
  localparam logic SEL_EXC  = 1'b1;

  typedef struct packed {
    logic takeExc;   // load handler target and restart address
    logic isTrap;    // restart address skips the instruction
    logic takeRet;   // load restart address into fetch
    logic wrBase;    // accepted write to handler base
    logic wrExc;     // accepted write to restart address
  } dpCtl_t;
endpackage

// File: rtl/exc_redirect_ctrl.sv
module exc_redirect_ctrl
  import exc_redirect_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   excValid,
  input  logic   excIsTrap,
  input  logic   retReq,
  input  logic   regWrEn,
  input  logic   regWrSel,
  input  logic   savedMode,
  output dpCtl_t ctl,
  output logic   privMode
);
  logic modeQ;

  always_comb begin
    ctl.takeExc = excValid;
    ctl.isTrap  = excIsTrap;
    ctl.takeRet = retReq && !excValid;
    ctl.wrBase  = regWrEn && modeQ && (regWrSel == SEL_BASE);
    ctl.wrExc   = regWrEn && modeQ && (regWrSel == SEL_EXC) && !excValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            modeQ <= 1'b1;
    else if (ctl.takeExc) modeQ <= 1'b1;
    else if (ctl.takeRet) modeQ <= savedMode;
  end

  assign privMode = modeQ;
endmodule

// File: rtl/exc_redirect_dp.sv
module exc_redirect_dp
  import exc_redirect_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int VEC_W = 12,
  parameter logic [PC_W-1:0] RESET_BASE = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtl_t          ctl,
  input  logic [PC_W-1:0] curPc,
  input  logic [VEC_W-1:0] vecOffset,
  input  logic [PC_W-1:0] regWrData,
  output logic            redirValid,
  output logic [PC_W-1:0] nextPc,
  output logic [PC_W-1:0] nextNextPc,
  output logic [PC_W-1:0] excAddr,
  output logic [PC_W-1:0] palBase
);
  localparam int PAD_W = PC_W - VEC_W;
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);
  localparam logic [PC_W-1:0] MODE_BIT   = PC_W'(1);

  logic [PC_W-1:0] baseQ, excQ, pcQ, pc2Q;
  logic            redirQ;
  logic [PC_W-1:0] handlerPc, restartPc, target;

  always_comb begin
    handlerPc = (baseQ + {{PAD_W{1'b0}}, vecOffset}) | MODE_BIT;
    restartPc = ctl.isTrap ? (curPc + INSN_BYTES) : curPc;
    target    = ctl.takeExc ? handlerPc : excQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= RESET_BASE;
      excQ   <= '0;
      pcQ    <= RESET_BASE | MODE_BIT;
      pc2Q   <= (RESET_BASE | MODE_BIT) + INSN_BYTES;
      redirQ <= 1'b0;
    end else begin
      if (ctl.wrBase)       baseQ <= regWrData;
      if (ctl.takeExc)      excQ  <= restartPc;
      else if (ctl.wrExc)   excQ  <= regWrData;
      redirQ <= ctl.takeExc || ctl.takeRet;
      if (ctl.takeExc || ctl.takeRet) begin
        pcQ  <= target;
        pc2Q <= target + INSN_BYTES;
      end
    end
  end

  assign redirValid = redirQ;
  assign nextPc     = pcQ;
  assign nextNextPc = pc2Q;
  assign excAddr    = excQ;
  assign palBase    = baseQ;
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_redirect_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int VEC_W = 12,
  parameter logic [PC_W-1:0] RESET_BASE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  curPc,
  input  logic             excValid,
  input  logic             excIsTrap,
  input  logic [VEC_W-1:0] vecOffset,
  input  logic             retReq,
  input  logic             regWrEn,
  input  logic             regWrSel,
  input  logic [PC_W-1:0]  regWrData,
  output logic             redirValid,
  output logic [PC_W-1:0]  nextPc,
  output logic [PC_W-1:0]  nextNextPc,
  output logic             privMode,
  output logic [PC_W-1:0]  excAddr,
  output logic [PC_W-1:0]  palBase
);
  dpCtl_t ctl;

  exc_redirect_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excIsTrap(excIsTrap),
    .retReq(retReq), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .savedMode(excAddr[0]), .ctl(ctl), .privMode(privMode)
  );

  exc_redirect_dp #(.PC_W(PC_W), .VEC_W(VEC_W), .RESET_BASE(RESET_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curPc(curPc), .vecOffset(vecOffset),
    .regWrData(regWrData), .redirValid(redirValid), .nextPc(nextPc),
    .nextNextPc(nextNextPc), .excAddr(excAddr), .palBase(palBase)
  );
endmodule

// File: rtl/exc_redirect_checker.sv
module exc_redirect_checker #(
  parameter int PC_W = 32,
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [PC_W-1:0]  curPc,
  input logic             excValid,
  input logic             excIsTrap,
  input logic [VEC_W-1:0] vecOffset,
  input logic             retReq,
  input logic             regWrEn,
  input logic             redirValid,
  input logic [PC_W-1:0]  nextPc,
  input logic [PC_W-1:0]  nextNextPc,
  input logic             privMode,
  input logic [PC_W-1:0]  excAddr,
  input logic [PC_W-1:0]  palBase
);
  a_r2_trap_skips: assert property (@(posedge clk) disable iff (!rstN)
    excValid && excIsTrap |=> excAddr == $past(curPc) + PC_W'(4));
  a_r3_fault_repeats: assert property (@(posedge clk) disable iff (!rstN)
    excValid && !excIsTrap |=> excAddr == $past(curPc));
  a_r4_handler_target: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> redirValid && nextPc ==
      (($past(palBase) + PC_W'($past(vecOffset))) | PC_W'(1)));
  a_r5_seq_pc: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> nextNextPc == nextPc + PC_W'(4));
  a_r6_enter_priv: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> privMode);
  a_r7_return: assert property (@(posedge clk) disable iff (!rstN)
    retReq && !excValid |=> redirValid && nextPc == $past(excAddr)
      && privMode == $past(excAddr[0]));
  a_r9_user_write_blocked: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && !privMode && !excValid && !retReq |=>
      $stable(palBase) && $stable(excAddr));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !excValid && !retReq |=> !redirValid && $stable(nextPc));
endmodule

bind exc_redirect exc_redirect_checker #(.PC_W(PC_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .curPc(curPc), .excValid(excValid),
  .excIsTrap(excIsTrap), .vecOffset(vecOffset), .retReq(retReq),
  .regWrEn(regWrEn), .redirValid(redirValid), .nextPc(nextPc),
  .nextNextPc(nextNextPc), .privMode(privMode), .excAddr(excAddr),
  .palBase(palBase)
);

// File: tb/sim_exc_redirect.sv
module sim_exc_redirect;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int VEC_W = 12;
  localparam logic [PC_W-1:0] RST_BASE = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] curPc = '0;
  logic excValid = 1'b0, excIsTrap = 1'b0, retReq = 1'b0;
  logic [VEC_W-1:0] vecOffset = '0;
  logic regWrEn = 1'b0, regWrSel = 1'b0;
  logic [PC_W-1:0] regWrData = '0;
  logic redirValid, privMode;
  logic [PC_W-1:0] nextPc, nextNextPc, excAddr, palBase;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_redirect #(.PC_W(PC_W), .VEC_W(VEC_W), .RESET_BASE(RST_BASE)) u0 (
    .clk(clk), .rstN(rstN), .curPc(curPc), .excValid(excValid),
    .excIsTrap(excIsTrap), .vecOffset(vecOffset), .retReq(retReq),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .redirValid(redirValid), .nextPc(nextPc), .nextNextPc(nextNextPc),
    .privMode(privMode), .excAddr(excAddr), .palBase(palBase)
  );

  typedef struct {
    string           tag;
    logic            redir;
    logic            priv;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] pc2;
    logic [PC_W-1:0] exc;
    logic [PC_W-1:0] base;
  } expect_t;

  expect_t expQ[$];
  int checks = 0;
  int fails = 0;

  // bench model state
  logic            mPriv, mRedir;
  logic [PC_W-1:0] mPc, mExc, mBase;

  task automatic report(string tag, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expect_t e;
      e = expQ.pop_front();
      checks++;
      report(e.tag, "redirValid", PC_W'(redirValid), PC_W'(e.redir));
      report(e.tag, "privMode",   PC_W'(privMode),   PC_W'(e.priv));
      report(e.tag, "nextPc",     nextPc,     e.pc);
      report(e.tag, "nextNextPc", nextNextPc, e.pc2);
      report(e.tag, "excAddr",    excAddr,    e.exc);
      report(e.tag, "palBase",    palBase,    e.base);
    end
  end

  task automatic pushModel(string tag);
    expect_t e;
    e.tag = tag; e.redir = mRedir; e.priv = mPriv; e.pc = mPc;
    e.pc2 = mPc + 32'd4; e.exc = mExc; e.base = mBase;
    expQ.push_back(e);
  endtask

  // driver: apply one cycle of stimulus and predict the result of the edge
  task automatic step(string tag, logic exc, logic trap, logic [PC_W-1:0] pc,
                      logic [VEC_W-1:0] vec, logic ret, logic wr, logic sel,
                      logic [PC_W-1:0] data);
    logic wrOk;
    logic [PC_W-1:0] oldExc, oldBase;
    @(negedge clk);
    excValid = exc; excIsTrap = trap; curPc = pc; vecOffset = vec;
    retReq = ret; regWrEn = wr; regWrSel = sel; regWrData = data;
    wrOk = wr && mPriv;
    oldExc = mExc; oldBase = mBase;
    if (wrOk && !sel) mBase = data;
    if (exc) begin
      mExc  = trap ? pc + 32'd4 : pc;
      mPc   = (oldBase + PC_W'(vec)) | 32'd1;
      mPriv = 1'b1;
      mRedir = 1'b1;
    end else begin
      if (wrOk && sel) mExc = data;
      if (ret) begin
        mPc = oldExc; mPriv = oldExc[0]; mRedir = 1'b1;
      end else mRedir = 1'b0;
    end
    pushModel(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mPriv = 1'b1; mRedir = 1'b0; mBase = RST_BASE; mExc = '0;
    mPc = RST_BASE | 32'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushModel("R1 reset state");              // checked at next edge, idle
    step("R11 idle after reset", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 priv write base", 0, 0, 0, 0, 0, 1, 0, 32'h0000_1000);
    step("R2 R4 R5 trap entry", 1, 1, 32'h0000_2001, 12'h100, 0, 0, 0, 0);
    step("R7 return stays priv", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R9 priv write excAddr", 0, 0, 0, 0, 0, 1, 1, 32'h0000_4000);
    step("R7 return to user", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R9 user write base ignored", 0, 0, 0, 0, 0, 1, 0, 32'h5555_5554);
    step("R9 user write excAddr ignored", 0, 0, 0, 0, 0, 1, 1, 32'h6666_6664);
    step("R3 R6 fault entry from user", 1, 0, 32'h0000_4010, 12'h080, 0, 0, 0, 0);
    step("R11 idle hold", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 exception beats return", 1, 1, 32'h0000_3000, 12'h040, 1, 0, 0, 0);
    step("R10 exception beats excAddr write", 1, 0, 32'h0000_7008, 12'hFFC, 0, 1, 1, 32'h0000_9000);
    step("R7 return to fault pc", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R9 user write still ignored", 0, 0, 0, 0, 0, 1, 0, 32'h0000_0100);
    step("R2 trap from user", 1, 1, 32'h0000_A00C, 12'h204, 0, 0, 0, 0);
    step("R11 idle end", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    excValid = 0; retReq = 0; regWrEn = 0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule